// File: doc/BRIEF.md
# Programmable-Priority Interrupt Arbiter

This block picks, on every clock, the one interrupt source that a processor core should take next. Twenty-eight level-sensitive request lines enter it, each gated by a per-source enable bit. Every source owns a 4-bit priority level. Three external-line sources have fixed levels; all others read their level from a 4-bit field of one of three software-writable 16-bit priority words, and several sources may share one field. The core supplies its current 4-bit interrupt mask and a global block bit. The arbiter answers with a registered request flag, the index of the winning source and that source's event code.

Software state is reached through plain write ports: one port replaces the whole enable vector, another writes one of the three priority words. No acknowledge handshake or edge detection exists; a source stays pending for as long as its line is high.

Source-to-level map (tie order is the index order): source 0, 1, 2 have fixed levels 6, 4, 2. Word A is selector 0, word B selector 1, word C selector 2; field n of a word is bits [4n+3:4n]. Source 3 uses C field 0; source 4 C field 3; sources 5 to 9 C field 2; source 10 A field 3; source 11 A field 2; sources 12 and 13 A field 1; sources 14 to 16 A field 0; sources 17 to 20 B field 1; sources 21 to 24 C field 1; source 25 B field 3; source 26 B field 2; source 27 A field 2.

Top module: `irq_prio_arbiter`

## Requirements
- R1: While and after reset, `irq_o` is 0, all enable bits are 1 and all three priority words are 0 (every programmable source at level 0).
- R2: Each source's level follows the source-to-level map above; a priority word write changes the level of every source sharing the written field.
- R3: A source is eligible only if its level is strictly greater than `mask_i`; a level-0 source is never taken and `mask_i` = 15 accepts nothing.
- R4: While `block_i` is 1, no source is accepted regardless of level.
- R5: Among eligible sources the highest level wins; among equal levels the source with the larger index wins.
- R6: A source whose enable bit (bit i of the vector written through `en_we`/`en_wdata`) is 0 is never accepted; a pending source with no request line high is never accepted.
- R7: When `irq_o` is 1, `win_src_o` is the winning index and `evt_o` equals 0x200 + 0x20 * `win_src_o`.
- R8: A change on `req_i`, `mask_i` or `block_i` appears at the outputs after the next rising edge; a write to an enable or priority word appears after the second rising edge.
- R9: A priority word write keeps all enable bits; a write with `prio_sel` = 3 changes nothing.
- R10: When `irq_o` is 0, `evt_o` and `win_src_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 28 | Level-sensitive request lines, one per source |
| en_we | input | 1 | Write strobe for the enable vector |
| en_wdata | input | 28 | New enable vector |
| prio_we | input | 1 | Write strobe for a priority word |
| prio_sel | input | 2 | Priority word select: 0 A, 1 B, 2 C, 3 none |
| prio_wdata | input | 16 | New priority word value |
| mask_i | input | 4 | Core's current interrupt mask level |
| block_i | input | 1 | Core's global interrupt block bit |
| irq_o | output | 1 | Registered interrupt request |
| win_src_o | output | 5 | Index of the winning source |
| evt_o | output | 12 | Event code of the winning source |

## Verification
The bound checker watches every cycle that reset, the block bit, a full mask and an idle request vector all leave the request flag low, that a reported winner had its line high in the cycle before, that the event code matches the index, and that idle outputs read zero. Which source wins for a given set of levels, how ties resolve by index, how shared priority fields move groups of sources together, the strict comparison against the mask, and the one- and two-edge latencies can only be shown by the bench's directed scenarios with computed expected winners.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int LVL_W = 4;

  typedef enum logic [1:0] {
    LSRC_FIXED = 2'd0,
    LSRC_A     = 2'd1,
    LSRC_B     = 2'd2,
    LSRC_C     = 2'd3
  } lvl_bank_e;

  typedef struct packed {
    lvl_bank_e  bank;
    logic [1:0] field;
  } lvl_ref_t;

  // Packed word holding the three fixed external-line levels (fields 0..2).
  localparam logic [15:0] FIXED_LVL_WORD = 16'h0246;

  // Where each source reads its level from. Order defines tie-break.
  function automatic lvl_ref_t src_ref(input int idx);
    lvl_ref_t r;
    r.bank  = LSRC_FIXED;
    r.field = 2'd0;
    if (idx <= 2) begin
      r.bank = LSRC_FIXED; r.field = 2'(idx);
    end else if (idx == 3) begin
      r.bank = LSRC_C; r.field = 2'd0;
    end else if (idx == 4) begin
      r.bank = LSRC_C; r.field = 2'd3;
    end else if (idx <= 9) begin
      r.bank = LSRC_C; r.field = 2'd2;
    end else if (idx == 10) begin
      r.bank = LSRC_A; r.field = 2'd3;
    end else if (idx == 11) begin
      r.bank = LSRC_A; r.field = 2'd2;
    end else if (idx <= 13) begin
      r.bank = LSRC_A; r.field = 2'd1;
    end else if (idx <= 16) begin
      r.bank = LSRC_A; r.field = 2'd0;
    end else if (idx <= 20) begin
      r.bank = LSRC_B; r.field = 2'd1;
    end else if (idx <= 24) begin
      r.bank = LSRC_C; r.field = 2'd1;
    end else if (idx == 25) begin
      r.bank = LSRC_B; r.field = 2'd3;
    end else if (idx == 26) begin
      r.bank = LSRC_B; r.field = 2'd2;
    end else begin
      r.bank = LSRC_A; r.field = 2'd2;
    end
    return r;
  endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int NUM_SRC  = 28,
  parameter int PRIO_W   = 16,
  parameter int NUM_BANK = 3,
  parameter int SEL_W    = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             en_we,
  input  logic [NUM_SRC-1:0]               en_wdata,
  input  logic                             prio_we,
  input  logic [SEL_W-1:0]                 prio_sel,
  input  logic [PRIO_W-1:0]                prio_wdata,
  output logic [NUM_SRC-1:0]               en_q,
  output logic [NUM_BANK-1:0][PRIO_W-1:0]  prio_q
);

  // Enable vector: all sources enabled out of reset (R1, R6).
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '1;
    end else if (en_we) begin
      en_q <= en_wdata;
    end
  end

  // One register per priority word; unused select codes hit nothing (R9).
  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        prio_q[b] <= '0;
      end else if (prio_we && (prio_sel == SEL_W'(b))) begin
        prio_q[b] <= prio_wdata;
      end
    end
  end

endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC  = 28,
  parameter int PRIO_W   = 16,
  parameter int NUM_BANK = 3
) (
  input  logic [NUM_BANK-1:0][PRIO_W-1:0] prio_q,
  output logic [NUM_SRC-1:0][LVL_W-1:0]   lvl
);

  // R2: each source picks one field of one word.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam lvl_ref_t REF = src_ref(i);
    logic [PRIO_W-1:0] word;
    always_comb begin
      case (REF.bank)
        LSRC_A:  word = prio_q[0];
        LSRC_B:  word = prio_q[1];
        LSRC_C:  word = prio_q[2];
        default: word = FIXED_LVL_WORD;
      endcase
      lvl[i] = word[{REF.field, 2'b00} +: LVL_W];
    end
  end

endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 28,
  parameter int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             req,
  input  logic [NUM_SRC-1:0]             en,
  input  logic [NUM_SRC-1:0][LVL_W-1:0]  lvl,
  input  logic [LVL_W-1:0]               mask,
  input  logic                           block,
  output logic                           hit,
  output logic [SRC_W-1:0]               win_idx
);

  logic [NUM_SRC-1:0] elig;

  // R3, R4, R6: qualification per source.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign elig[i] = req[i] & en[i] & (lvl[i] > mask) & ~block;
  end

  // R5: highest level wins; >= lets a later index take a tie.
  logic [LVL_W-1:0] best_lvl;
  always_comb begin
    hit      = 1'b0;
    best_lvl = '0;
    win_idx  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!hit || (lvl[i] >= best_lvl))) begin
        hit      = 1'b1;
        best_lvl = lvl[i];
        win_idx  = SRC_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int          NUM_SRC  = 28,
  parameter int          PRIO_W   = 16,
  parameter int          NUM_BANK = 3,
  parameter int          SEL_W    = 2,
  parameter int          EVT_W    = 12,
  parameter logic [11:0] EVT_BASE = 12'h200,
  parameter logic [11:0] EVT_STEP = 12'h020,
  localparam int         SRC_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               en_we,
  input  logic [NUM_SRC-1:0] en_wdata,
  input  logic               prio_we,
  input  logic [SEL_W-1:0]   prio_sel,
  input  logic [PRIO_W-1:0]  prio_wdata,
  input  logic [LVL_W-1:0]   mask_i,
  input  logic               block_i,
  output logic               irq_o,
  output logic [SRC_W-1:0]   win_src_o,
  output logic [EVT_W-1:0]   evt_o
);

  logic [NUM_SRC-1:0]              en_q;
  logic [NUM_BANK-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_SRC-1:0][LVL_W-1:0]   lvl;
  logic                            hit;
  logic [SRC_W-1:0]                win_idx;

  irq_cfg_regs #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .NUM_BANK(NUM_BANK),
    .SEL_W   (SEL_W)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .en_we     (en_we),
    .en_wdata  (en_wdata),
    .prio_we   (prio_we),
    .prio_sel  (prio_sel),
    .prio_wdata(prio_wdata),
    .en_q      (en_q),
    .prio_q    (prio_q)
  );

  irq_level_map #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .NUM_BANK(NUM_BANK)
  ) u_map (
    .prio_q(prio_q),
    .lvl   (lvl)
  );

  irq_select #(
    .NUM_SRC(NUM_SRC),
    .SRC_W  (SRC_W)
  ) u_sel (
    .req    (req_i),
    .en     (en_q),
    .lvl    (lvl),
    .mask   (mask_i),
    .block  (block_i),
    .hit    (hit),
    .win_idx(win_idx)
  );

  // R7, R8, R10: registered result, zeroed when idle.
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= 1'b0;
      win_src_o <= '0;
      evt_o     <= '0;
    end else if (hit) begin
      irq_o     <= 1'b1;
      win_src_o <= win_idx;
      evt_o     <= EVT_W'(EVT_BASE) + EVT_W'(win_idx) * EVT_W'(EVT_STEP);
    end else begin
      irq_o     <= 1'b0;
      win_src_o <= '0;
      evt_o     <= '0;
    end
  end

endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
  parameter int          NUM_SRC  = 28,
  parameter int          SRC_W    = 5,
  parameter int          EVT_W    = 12,
  parameter logic [11:0] EVT_BASE = 12'h200,
  parameter logic [11:0] EVT_STEP = 12'h020
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] req_i,
  input logic [3:0]         mask_i,
  input logic               block_i,
  input logic               irq_o,
  input logic [SRC_W-1:0]   win_src_o,
  input logic [EVT_W-1:0]   evt_o
);

  logic [NUM_SRC-1:0] req_q;
  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= req_i;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !irq_o);

  p_full_mask_r3: assert property (@(posedge clk) disable iff (rst)
    (mask_i == 4'hF) |=> !irq_o);

  p_block_r4: assert property (@(posedge clk) disable iff (rst)
    block_i |=> !irq_o);

  p_no_request_r6: assert property (@(posedge clk) disable iff (rst)
    (req_i == '0) |=> !irq_o);

  p_event_code_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (evt_o == EVT_W'(EVT_BASE) + EVT_W'(win_src_o) * EVT_W'(EVT_STEP)));

  p_winner_pending_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ((32'(win_src_o) < NUM_SRC) && req_q[win_src_o]));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !irq_o |-> ((evt_o == '0) && (win_src_o == '0)));

endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(
  .NUM_SRC (NUM_SRC),
  .SRC_W   (SRC_W),
  .EVT_W   (EVT_W),
  .EVT_BASE(EVT_BASE),
  .EVT_STEP(EVT_STEP)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_i    (req_i),
  .mask_i   (mask_i),
  .block_i  (block_i),
  .irq_o    (irq_o),
  .win_src_o(win_src_o),
  .evt_o    (evt_o)
);

// File: tb/sim_irq_prio_arbiter.sv
module sim_irq_prio_arbiter;

  logic        clk = 1'b0;
  logic        rst;
  logic [27:0] req_i;
  logic        en_we;
  logic [27:0] en_wdata;
  logic        prio_we;
  logic [1:0]  prio_sel;
  logic [15:0] prio_wdata;
  logic [3:0]  mask_i;
  logic        block_i;
  logic        irq_o;
  logic [4:0]  win_src_o;
  logic [11:0] evt_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_prio_arbiter u0 (
    .clk(clk), .rst(rst), .req_i(req_i),
    .en_we(en_we), .en_wdata(en_wdata),
    .prio_we(prio_we), .prio_sel(prio_sel), .prio_wdata(prio_wdata),
    .mask_i(mask_i), .block_i(block_i),
    .irq_o(irq_o), .win_src_o(win_src_o), .evt_o(evt_o)
  );

  task automatic check(input bit exp_irq, input int exp_src, input string tag);
    logic [11:0] exp_evt;
    logic [4:0]  exp_s;
    exp_s   = exp_irq ? 5'(exp_src) : 5'd0;
    exp_evt = exp_irq ? (12'h200 + 12'(exp_src) * 12'h020) : 12'h000;
    checks++;
    if (irq_o !== exp_irq || win_src_o !== exp_s || evt_o !== exp_evt) begin
      errors++;
      $display("FAIL %s: irq=%0b src=%0d evt=%h expected irq=%0b src=%0d evt=%h",
               tag, irq_o, win_src_o, evt_o, exp_irq, exp_s, exp_evt);
    end
  endtask

  // Drive at a falling edge, then let two rising edges pass.
  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic write_prio(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    prio_we = 1'b1; prio_sel = sel; prio_wdata = val;
    @(negedge clk);
    prio_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_en(input logic [27:0] val);
    @(negedge clk);
    en_we = 1'b1; en_wdata = val;
    @(negedge clk);
    en_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(1'b0, 0, "R1 idle after reset");
    check(1'b0, 0, "R10 idle outputs zero");
    req_i = '1; mask_i = 4'd0; block_i = 1'b0;
    settle();
    check(1'b1, 0, "R1/R2 fixed level 6 wins, all enabled");
  endtask

  task automatic t_mask();
    mask_i = 4'd5; settle();
    check(1'b1, 0, "R3 level 6 over mask 5");
    mask_i = 4'd6; settle();
    check(1'b0, 0, "R3 level 6 not over mask 6");
    req_i = 28'h0000006; mask_i = 4'd3; settle();
    check(1'b1, 1, "R2 source 1 level 4 over mask 3");
    mask_i = 4'd4; settle();
    check(1'b0, 0, "R3 source 2 level 2 under mask 4");
    req_i = 28'h0000008; mask_i = 4'd0; settle();
    check(1'b0, 0, "R3 level 0 never taken");
  endtask

  task automatic t_block();
    req_i = '1; mask_i = 4'd0; block_i = 1'b1; settle();
    check(1'b0, 0, "R4 block inhibits");
    @(negedge clk); block_i = 1'b0;
    #1 check(1'b0, 0, "R8 no change before edge");
    @(negedge clk);
    check(1'b1, 0, "R8 block release after one edge");
  endtask

  task automatic t_priority();
    write_prio(2'd2, 16'h0900);
    check(1'b1, 9, "R5 tie among sources 5..9 goes to 9");
    req_i = 28'h0000060; settle();
    check(1'b1, 6, "R5 tie between 5 and 6 goes to 6");
    req_i = '1;
    write_prio(2'd0, 16'h0900);
    check(1'b1, 27, "R2/R5 shared field A2 ties at 9, 27 wins");
    write_prio(2'd1, 16'hF000);
    check(1'b1, 25, "R5 level 15 beats later index");
    mask_i = 4'd15; settle();
    check(1'b0, 0, "R3 full mask accepts nothing");
    mask_i = 4'd0; settle();
  endtask

  task automatic t_enable();
    write_en(28'hDFFFFFF);
    check(1'b1, 27, "R6 disabled source 25 skipped");
    write_prio(2'd2, 16'h0A00);
    check(1'b1, 9, "R9 priority write keeps enable bit 25 clear");
    write_prio(2'd3, 16'hFFFF);
    check(1'b1, 9, "R9 select 3 changes nothing");
    req_i = 28'h0000200; write_en(28'h0000000);
    check(1'b0, 0, "R6 all disabled");
    write_en('1);
    check(1'b1, 9, "R6 re-enabled");
  endtask

  task automatic t_timing();
    @(negedge clk); req_i = 28'h0000000;
    @(negedge clk);
    check(1'b0, 0, "R8 request drop after one edge");
    req_i = 28'h0000200; settle();
    @(negedge clk);
    prio_we = 1'b1; prio_sel = 2'd2; prio_wdata = 16'h0000;
    @(negedge clk);
    prio_we = 1'b0;
    check(1'b1, 9, "R8 write not visible after one edge");
    @(negedge clk);
    check(1'b0, 0, "R8 write visible after two edges");
  endtask

  initial begin
    rst = 1'b1; req_i = '0; en_we = 1'b0; en_wdata = '0;
    prio_we = 1'b0; prio_sel = '0; prio_wdata = '0;
    mask_i = '0; block_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mask();
    t_block();
    t_priority();
    t_enable();
    t_timing();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: done=0 expected done=1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule